// File: doc/BRIEF.md
# Receive Address Filter

This block decides whether a frame addressed to a given 48-bit destination MAC address should be accepted. It combines two filters. The first is a small table of exact-match address slots. Slot 0 normally holds the station address, and the other slots hold multicast groups. The second is a 4096-bit multicast hash bitmap that catches the groups that do not fit in the slots. Software programs both through a plain register write/read port. Software sets a hash bit by reading the selected 32-bit word, ORing in the bit and writing the word back.

Lookups arrive on a valid/ready stream. A destination address is taken when `da_valid` and `da_ready` are both high on a rising edge. The verdict appears on a second valid/ready stream one cycle later. The block applies back-pressure: `da_ready` is high only when the result register is empty or is being drained in that same cycle (`res_ready` high). While `res_valid` is high and `res_ready` is low, the result is held unchanged and no new address is taken. The 2-bit `filt_mode` control selects the window of the address that forms the hash.

Top module: `rxf_addr_filter`

## Requirements
- R1: After reset every exact-match slot is invalid and every hash word is zero: all of them read back 0, and any lookup is rejected.
- R2: Register map, using an 8-bit index at default parameters. Slot n has its low word at index 2n and its high word at index 2n+1, for n = 0..15. Hash word w sits at index 128+w (index bit 7 set), for w = 0..127. Indices 32..127 read 0 and ignore writes.
- R3: Address byte k is da_addr[8k+7:8k], and byte 0 is sent first. The low word holds bytes 0..3, with byte 0 in bits 7:0. The high word holds bytes 4..5 in bits 15:0 and the slot-valid flag in bit 31. Bits 30:16 of the high word read back 0.
- R4: A lookup is accepted when a valid slot equals the address in all 48 bits. Changing any single address bit breaks that match.
- R5: A slot whose valid flag is clear never matches, even if its stored address equals the lookup address.
- R6: The 12-bit hash is taken from address bits 47:36 when filt_mode=0, 46:35 when filt_mode=1, 45:34 when filt_mode=2, and 43:32 when filt_mode=3. For bytes 01 AA 00 12 34 56 this gives 0x563, 0xAC6, 0x58D and 0x634 respectively.
- R7: Hash bits 11:5 select the hash word, and hash bits 4:0 select the bit within it. A multicast address with no exact match is accepted exactly when that bit is 1.
- R8: An address is multicast when da_addr[0] (bit 0 of byte 0) is 1. A non-multicast address with no exact match is rejected whatever the hash bitmap holds.
- R9: The verdict appears on res_valid/res_accept on the edge after the one on which the address was taken. While res_valid is high and res_ready is low, res_valid and res_accept hold, and da_ready is low.
- R10: A register write on the same edge as a lookup does not affect that lookup. It takes effect from the next lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| filt_mode | input | 2 | Hash window select |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| da_valid | input | 1 | Destination address valid |
| da_ready | output | 1 | Block can take an address |
| da_addr | input | 48 | Destination address, byte k at bits 8k+7:8k |
| res_valid | output | 1 | Verdict valid |
| res_ready | input | 1 | Consumer takes the verdict |
| res_accept | output | 1 | 1 = accept, 0 = reject |

## Verification
The bench builds the block with its default parameters: 16 slots and 128 hash words of 32 bits. At that size every slot and every hash word can be swept. In each of the four window modes, one bit is set in each hash word in turn, and the bench checks that the matching multicast address is accepted, that a neighbouring hash is rejected, and that the unicast twin is rejected. The bench also checks each slot for a full match and for a single-bit miss, the published example hashes, back-pressure holding, and a write that collides with a lookup.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int MAC_W = 48;

  typedef enum logic [1:0] {
    WIN_47_36 = 2'd0,
    WIN_46_35 = 2'd1,
    WIN_45_34 = 2'd2,
    WIN_43_32 = 2'd3
  } hash_win_e;

  // lowest address bit that feeds the hash for a given window
  function automatic int win_lsb(hash_win_e w);
    case (w)
      WIN_47_36: return 36;
      WIN_46_35: return 35;
      WIN_45_34: return 34;
      default:   return 32;
    endcase
  endfunction

endpackage

// File: rtl/rxf_hash_window.sv
module rxf_hash_window
  import rxf_pkg::*;
#(
  parameter int HASH_W = 12
) (
  input  logic [1:0]        mode,
  input  logic [MAC_W-1:0]  addr,
  output logic [HASH_W-1:0] hash
);
  logic [MAC_W-1:0] shifted;

  always_comb begin
    shifted = addr >> win_lsb(hash_win_e'(mode));
    hash    = shifted[HASH_W-1:0];
  end
endmodule

// File: rtl/rxf_exact_table.sv
module rxf_exact_table
  import rxf_pkg::*;
#(
  parameter int N_ENT  = 16,
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(2 * N_ENT),
  localparam int ENT_W = IDX_W - 1,
  localparam int VALID_BIT = WORD_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_data,
  input  logic [MAC_W-1:0]  lk_addr,
  output logic              hit
);
  logic [31:0] lo_q [N_ENT];
  logic [15:0] hi_q [N_ENT];
  logic [N_ENT-1:0] av_q;
  logic [N_ENT-1:0] match_vec;

  logic [ENT_W-1:0] wr_ent;
  logic [ENT_W-1:0] rd_ent;
  logic unused_hi_bits;

  assign wr_ent = wr_idx[IDX_W-1:1];
  assign rd_ent = rd_idx[IDX_W-1:1];
  assign unused_hi_bits = ^wr_data[VALID_BIT-1:16];

  for (genvar i = 0; i < N_ENT; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q[i] <= '0;
        hi_q[i] <= '0;
        av_q[i] <= 1'b0;
      end else if (wr_en && (32'(wr_ent) == i)) begin
        if (wr_idx[0]) begin
          hi_q[i] <= wr_data[15:0];
          av_q[i] <= wr_data[VALID_BIT];
        end else begin
          lo_q[i] <= wr_data[31:0];
        end
      end
    end
    assign match_vec[i] = av_q[i] && ({hi_q[i], lo_q[i]} == lk_addr);
  end

  assign hit = |match_vec;

  always_comb begin
    rd_data = '0;
    if (32'(rd_ent) < N_ENT) begin
      if (rd_idx[0]) begin
        rd_data[15:0]      = hi_q[rd_ent];
        rd_data[VALID_BIT] = av_q[rd_ent];
      end else begin
        rd_data[31:0] = lo_q[rd_ent];
      end
    end
  end

  // R5
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (av_q != '0));

  // R3
  valid_flag_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx[0] && (32'(wr_ent) < N_ENT))
      |=> av_q[$past(wr_ent)] == $past(wr_data[VALID_BIT]));

  // R3
  low_word_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_idx[0] && (32'(wr_ent) < N_ENT))
      |=> lo_q[$past(wr_ent)] == $past(wr_data[31:0]));
endmodule

// File: rtl/rxf_hash_table.sv
module rxf_hash_table #(
  parameter int WORDS  = 128,
  parameter int WORD_W = 32,
  localparam int WSEL_W = $clog2(WORDS),
  localparam int BSEL_W = $clog2(WORD_W),
  localparam int HASH_W = WSEL_W + BSEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WSEL_W-1:0] wr_word,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [WSEL_W-1:0] rd_word,
  output logic [WORD_W-1:0] rd_data,
  input  logic [HASH_W-1:0] lk_hash,
  output logic              lk_bit
);
  logic [WORD_W-1:0] mem_q [WORDS];
  logic [WORD_W-1:0] sel_word;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem_q[w] <= '0;
      else if (wr_en && (32'(wr_word) == w))
        mem_q[w] <= wr_data;
    end
  end

  assign rd_data  = mem_q[rd_word];
  assign sel_word = mem_q[lk_hash[HASH_W-1:BSEL_W]];
  assign lk_bit   = sel_word[lk_hash[BSEL_W-1:0]];

  // R7
  hash_word_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem_q[$past(wr_word)] == $past(wr_data));
endmodule

// File: rtl/rxf_addr_filter.sv
module rxf_addr_filter
  import rxf_pkg::*;
#(
  parameter int N_ENT      = 16,
  parameter int HASH_WORDS = 128,
  parameter int WORD_W     = 32,
  localparam int IDX_W  = $clog2(2 * N_ENT),
  localparam int WSEL_W = $clog2(HASH_WORDS),
  localparam int HASH_W = WSEL_W + $clog2(WORD_W),
  localparam int REG_AW = ((IDX_W > WSEL_W) ? IDX_W : WSEL_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        filt_mode,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              da_valid,
  output logic              da_ready,
  input  logic [MAC_W-1:0]  da_addr,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_accept
);
  logic in_hash_rgn, exact_ok, hash_ok;
  logic [REG_AW-2:0] rgn_off;
  logic [WORD_W-1:0] exact_rd, hash_rd;
  logic [HASH_W-1:0] lk_hash;
  logic exact_hit, hash_bit, fire;
  logic res_valid_q, res_accept_q;

  assign in_hash_rgn = reg_addr[REG_AW-1];
  assign rgn_off     = reg_addr[REG_AW-2:0];
  assign exact_ok    = !in_hash_rgn && (32'(rgn_off) < 2 * N_ENT);
  assign hash_ok     =  in_hash_rgn && (32'(rgn_off) < HASH_WORDS);

  rxf_exact_table #(.N_ENT(N_ENT), .WORD_W(WORD_W)) exact_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr && exact_ok),
    .wr_idx  (reg_addr[IDX_W-1:0]),
    .wr_data (reg_wdata),
    .rd_idx  (reg_addr[IDX_W-1:0]),
    .rd_data (exact_rd),
    .lk_addr (da_addr),
    .hit     (exact_hit)
  );

  rxf_hash_window #(.HASH_W(HASH_W)) win_i (
    .mode (filt_mode),
    .addr (da_addr),
    .hash (lk_hash)
  );

  rxf_hash_table #(.WORDS(HASH_WORDS), .WORD_W(WORD_W)) hash_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr && hash_ok),
    .wr_word (reg_addr[WSEL_W-1:0]),
    .wr_data (reg_wdata),
    .rd_word (reg_addr[WSEL_W-1:0]),
    .rd_data (hash_rd),
    .lk_hash (lk_hash),
    .lk_bit  (hash_bit)
  );

  always_comb begin
    if (exact_ok)     reg_rdata = exact_rd;
    else if (hash_ok) reg_rdata = hash_rd;
    else              reg_rdata = '0;
  end

  assign da_ready = !res_valid_q || res_ready;
  assign fire     = da_valid && da_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid_q  <= 1'b0;
      res_accept_q <= 1'b0;
    end else if (fire) begin
      res_valid_q  <= 1'b1;
      res_accept_q <= exact_hit || (da_addr[0] && hash_bit);
    end else if (res_ready) begin
      res_valid_q  <= 1'b0;
    end
  end

  assign res_valid  = res_valid_q;
  assign res_accept = res_accept_q;

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_accept)));

  // R9
  result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && da_ready) |=> res_valid);

  // R8
  unicast_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && da_ready && !da_addr[0] && !exact_hit) |=> !res_accept);

  // R4
  exact_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && da_ready && exact_hit) |=> res_accept);
endmodule

// File: tb/rxf_addr_filter_tb_top.sv
module rxf_addr_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  filt_mode = 2'd0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        da_valid = 1'b0;
  logic        da_ready;
  logic [47:0] da_addr = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_accept;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  logic [31:0] m_lo [16];
  logic [15:0] m_hi [16];
  logic        m_av [16];
  logic [31:0] m_hash [128];

  always #10 clk = ~clk;

  rxf_addr_filter dut_i (
    .clk(clk), .rst_n(rst_n), .filt_mode(filt_mode),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .da_valid(da_valid), .da_ready(da_ready),
    .da_addr(da_addr), .res_valid(res_valid), .res_ready(res_ready),
    .res_accept(res_accept)
  );

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  task automatic chk(input logic [47:0] act, input logic [47:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] hash_of(input logic [47:0] a, input logic [1:0] m);
    int sh;
    logic [47:0] s;
    sh = (m == 2'd0) ? 36 : (m == 2'd1) ? 35 : (m == 2'd2) ? 34 : 32;
    s = a >> sh;
    return s[11:0];
  endfunction

  function automatic logic model_accept(input logic [47:0] a);
    logic [11:0] h;
    logic [31:0] wv;
    for (int i = 0; i < 16; i++)
      if (m_av[i] && {m_hi[i], m_lo[i]} == a) return 1'b1;
    h = hash_of(a, filt_mode);
    wv = m_hash[h[11:5]];
    return a[0] && wv[h[4:0]];
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    if (a[7]) m_hash[a[6:0]] = d;
    else if (a < 8'd32) begin
      if (a[0]) begin m_hi[a[4:1]] = d[15:0]; m_av[a[4:1]] = d[31]; end
      else m_lo[a[4:1]] = d;
    end
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk({16'h0, reg_rdata}, {16'h0, exp}, tag);
  endtask

  task automatic look(input logic [47:0] a, input logic exp, input string tag);
    @(negedge clk);
    da_valid = 1'b1; da_addr = a; res_ready = 1'b1;
    @(negedge clk);
    da_valid = 1'b0;
    chk({47'h0, res_valid}, 48'h1, {tag, " valid"});
    chk({47'h0, res_accept}, {47'h0, exp}, tag);
  endtask

  task automatic set_slot(input int n, input logic [47:0] a, input logic v);
    wr(8'(2 * n + 1), 32'h0);
    wr(8'(2 * n), a[31:0]);
    wr(8'(2 * n + 1), {v, 15'h0, a[47:32]});
  endtask

  logic [47:0] addr_tmp;
  logic [11:0] h;

  initial begin
    for (int i = 0; i < 16; i++) begin m_lo[i] = '0; m_hi[i] = '0; m_av[i] = 1'b0; end
    for (int i = 0; i < 128; i++) m_hash[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset contents and reject
    for (int i = 0; i < 32; i++) rd_chk(8'(i), 32'h0, "R1 slot reset");
    for (int i = 0; i < 128; i++) rd_chk(8'(128 + i), 32'h0, "R1 hash reset");
    look(48'hFFFF_FFFF_FFFF, 1'b0, "R1 reject after reset");

    // R2 hole region ignores writes and reads zero
    wr(8'd40, 32'hDEAD_BEEF);
    rd_chk(8'd40, 32'h0, "R2 hole read");

    // R2 R3 layout, R4 exact match per slot
    for (int n = 0; n < 16; n++) begin
      addr_tmp = {8'h56 ^ 8'(n), 8'h34, 8'h12, 8'h00, 8'hA0 + 8'(n), 7'(n), 1'(n & 1)};
      wr(8'(2 * n), addr_tmp[31:0]);
      wr(8'(2 * n + 1), {1'b1, 15'h7ABC, addr_tmp[47:32]});
      rd_chk(8'(2 * n), addr_tmp[31:0], "R2 low word");
      rd_chk(8'(2 * n + 1), {1'b1, 15'h0, addr_tmp[47:32]}, "R3 high word");
      look(addr_tmp, 1'b1, "R4 slot hit");
      look(addr_tmp ^ (48'h1 << (n * 3)), model_accept(addr_tmp ^ (48'h1 << (n * 3))), "R4 one-bit miss");
    end

    // R5 invalid slot never matches
    addr_tmp = {m_hi[5], m_lo[5]};
    wr(8'd11, {16'h0, m_hi[5]});
    look(addr_tmp, 1'b0, "R5 invalid slot");
    rd_chk(8'd10, m_lo[5], "R5 low kept");

    // R6 published example values
    addr_tmp = 48'h5634_1200_AA01;
    for (int m = 0; m < 4; m++) begin
      filt_mode = 2'(m);
      h = hash_of(addr_tmp, 2'(m));
      chk({36'h0, h}, (m == 0) ? 48'h563 : (m == 1) ? 48'hAC6 : (m == 2) ? 48'h58D : 48'h634, "R6 example hash");
      wr(8'(128 + h[11:5]), 32'h1 << h[4:0]);
      look(addr_tmp, 1'b1, "R6 example accept");
      wr(8'(128 + h[11:5]), 32'h0);
      look(addr_tmp, 1'b0, "R6 example cleared");
    end

    // R6 R7 R8 sweep of every hash word in every window
    for (int m = 0; m < 4; m++) begin
      filt_mode = 2'(m);
      for (int w = 0; w < 128; w++) begin
        h = {7'(w), 5'((w * 7 + m) % 32)};
        wr(8'(128 + w), 32'h1 << h[4:0]);
        addr_tmp = (48'(h) << ((m == 0) ? 36 : (m == 1) ? 35 : (m == 2) ? 34 : 32)) | 48'h1;
        look(addr_tmp, model_accept(addr_tmp), "R7 hash bit hit");
        look(addr_tmp ^ (48'h1 << ((m == 0) ? 36 : (m == 1) ? 35 : (m == 2) ? 34 : 32)),
             1'b0, "R7 neighbour bit");
        look(addr_tmp & ~48'h1, 1'b0, "R8 unicast ignores hash");
        wr(8'(128 + w), 32'h0);
      end
    end
    filt_mode = 2'd0;

    // R9 back-pressure
    @(negedge clk);
    res_ready = 1'b0; da_valid = 1'b1; da_addr = {m_hi[3], m_lo[3]};
    @(negedge clk);
    da_addr = 48'h0000_0000_0002;
    chk({47'h0, res_valid}, 48'h1, "R9 result one cycle later");
    chk({47'h0, res_accept}, 48'h1, "R9 result value");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk({47'h0, da_ready}, 48'h0, "R9 ready low while stalled");
      chk({47'h0, res_accept}, 48'h1, "R9 result held");
    end
    res_ready = 1'b1;
    @(negedge clk);
    da_valid = 1'b0;
    chk({47'h0, res_valid}, 48'h1, "R9 next result");
    chk({47'h0, res_accept}, 48'h0, "R9 next result value");

    // R10 write colliding with lookup
    addr_tmp = 48'h0102_0304_0506;
    set_slot(7, addr_tmp, 1'b0);
    @(negedge clk);
    da_valid = 1'b1; da_addr = addr_tmp;
    reg_wr = 1'b1; reg_addr = 8'd15; reg_wdata = {1'b1, 15'h0, addr_tmp[47:32]};
    m_av[7] = 1'b1;
    @(negedge clk);
    da_valid = 1'b0; reg_wr = 1'b0;
    chk({47'h0, res_accept}, 48'h0, "R10 same-cycle write unseen");
    look(addr_tmp, 1'b1, "R10 next lookup sees write");

    finish_run();
  end
endmodule